// File: doc/BRIEF.md
# Transmit Session Timeout Controller

This block caps the length of a single transmit session on a shared line. A mode input chooses the direction: high means receive and low means transmit. When the mode input is sampled low while the block is idle, the transmit-enable gate opens. The gate stays open until the mode input returns high, or until the selected time limit runs out. A 2-bit selection sets the limit to one second, three seconds or no limit at all. The block captures this selection when each session starts.

When a session runs past its limit, the block closes the gate and sets a timeout flag. The flag then stays set for a mandatory off period of 125 ms. It also stays set until the mode input has been seen high for 20 µs without a break. A new session cannot begin while the flag is set.

Every duration is counted in clock cycles of a reference clock. By default that clock runs at 16 MHz, and each duration is a parameter given in microseconds.

Top module: `tx_session_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_enable and tmo_flag are both 0.
- R2: With the flag clear, the clock edge that first samples mode_rx = 0 raises tx_enable. The first edge that samples mode_rx = 1 lowers it, and the flag stays 0.
- R3: With tmo_sel = 01 captured at the start of a session, tx_enable stays high for exactly SHORT_US × CLK_MHZ cycles if mode_rx is held at 0. The edge that lowers it also raises tmo_flag. With the default parameters this is 1 s.
- R4: With tmo_sel = 10 or 11 captured, the same happens after exactly LONG_US × CLK_MHZ cycles. With the default parameters this is 3 s.
- R5: With tmo_sel = 00 captured, a session has no limit. tx_enable stays high and tmo_flag stays 0 for as long as mode_rx stays 0.
- R6: tmo_sel is captured at the edge that opens a session. Changes to it during the session have no effect on that session's limit.
- R7: Once set, tmo_flag stays high for at least OFF_US × CLK_MHZ cycles (125 ms by default), even when mode_rx is already high.
- R8: tmo_flag clears only when two conditions hold. The off time must have elapsed, and mode_rx must have been sampled high on REL_US × CLK_MHZ consecutive edges (20 µs by default). A single low sample restarts that count.
- R9: While tmo_flag is high, tx_enable stays 0 whatever mode_rx does. After the flag clears, a new session needs mode_rx to be sampled low again.
- R10: If mode_rx is sampled high at the very edge where the limit would expire, the session ends normally and tmo_flag stays 0.
- R11: tx_enable and tmo_flag are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rx | input | 1 | Mode: 1 = receive, 0 = transmit; assumed synchronous to clk |
| tmo_sel | input | 2 | Limit select: 00 none, 01 short, 10/11 long |
| tx_enable | output | 1 | Transmit gate, high while a session is allowed |
| tmo_flag | output | 1 | Timeout status, 1 after a timeout until released |

## Verification
Two things can happen at the same clock edge: the session limit can expire, and the mode input can return to receive. The bench provokes this by raising mode_rx one cycle before the expected trip, so that it is first sampled at the expiry edge. The result is judged correct only if the gate closes and the flag stays clear. A run that raises mode_rx one cycle later must trip. In the same way, the end of the off time and the end of the release count are made to fall together, or are set apart by restarting the release count with a one-cycle dip. The flag must fall at the later of the two events.

// File: rtl/txg_pkg.sv
// Shared types for the transmit session guard.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package txg_pkg;

    // Limit selection code as driven on tmo_sel.
    typedef enum logic [1:0] {
        LIM_NONE  = 2'b00,
        LIM_SHORT = 2'b01,
        LIM_LONG  = 2'b10,
        LIM_LONG2 = 2'b11
    } lim_sel_e;

    // Controller state.
    typedef enum logic [1:0] {
        ST_RECV = 2'b00,
        ST_SEND = 2'b01,
        ST_HOLD = 2'b10
    } guard_state_e;

endpackage

// File: rtl/txg_span_timer.sv
// Cycle counter that runs while 'run' is high and clears while it is low.
// 'done' is high in the cycle the count reaches span-1. While run stays
// high, the count saturates there, so 'done' stays asserted.
// Assumes span >= 1 and that span is stable while run is high.
module txg_span_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] span,
    output logic          done
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;

    assign last_c = span - CW'(1);

    // Count up while running, hold at the last value, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != last_c) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = run && (cnt_q == last_c);

endmodule

// File: rtl/txg_limit_latch.sv
// Captures the limit selection when a session opens. It converts the
// selection into a cycle span and an 'armed' bit (0 when there is no limit).
// Assumes capture is a single-cycle pulse at the start of a session.
module txg_limit_latch
    import txg_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned SHORT_CYC = 10,
    parameter int unsigned LONG_CYC  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [1:0]    sel,
    output logic [CW-1:0] span,
    output logic          armed
);

    lim_sel_e      sel_c;
    logic [CW-1:0] span_c;
    logic          arm_c;

    assign sel_c = lim_sel_e'(sel);

    // Decode the selection into a span and an armed bit.
    always_comb begin
        unique case (sel_c)
            LIM_NONE:  begin span_c = CW'(LONG_CYC);  arm_c = 1'b0; end
            LIM_SHORT: begin span_c = CW'(SHORT_CYC); arm_c = 1'b1; end
            default:   begin span_c = CW'(LONG_CYC);  arm_c = 1'b1; end
        endcase
    end

    // Hold the decoded limit for the whole session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span  <= CW'(LONG_CYC);
            armed <= 1'b0;
        end else if (capture) begin
            span  <= span_c;
            armed <= arm_c;
        end
    end

endmodule

// File: rtl/txg_ctrl_fsm.sv
// Three-state session controller: receive, send, hold-off.
// Both outputs are decoded from the state register, so neither glitches.
// In the send state, a sampled mode_rx = 1 takes priority over expiry.
module txg_ctrl_fsm
    import txg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_rx,
    input  logic         sess_done,
    input  logic         armed,
    input  logic         off_done,
    input  logic         rel_done,
    output guard_state_e state,
    output logic         tx_enable,
    output logic         tmo_flag
);

    guard_state_e nxt_c;

    // Next-state decision.
    always_comb begin
        nxt_c = state;
        unique case (state)
            ST_RECV: if (!mode_rx) nxt_c = ST_SEND;
            ST_SEND: begin
                if (mode_rx)                 nxt_c = ST_RECV;
                else if (armed && sess_done) nxt_c = ST_HOLD;
            end
            ST_HOLD: if (off_done && rel_done) nxt_c = ST_RECV;
            default: nxt_c = ST_RECV;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RECV;
        else        state <= nxt_c;
    end

    assign tx_enable = (state == ST_SEND);
    assign tmo_flag  = (state == ST_HOLD);

endmodule

// File: rtl/tx_session_guard.sv
// Transmit session guard. It limits transmit sessions to a selectable
// length, then enforces an off time and a release delay on the mode input.
// Assumes mode_rx and tmo_sel are synchronous to clk. Durations are in
// microseconds and are scaled by CLK_MHZ into cycle counts.
module tx_session_guard
    import txg_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 16,
    parameter int unsigned SHORT_US = 1_000_000,
    parameter int unsigned LONG_US  = 3_000_000,
    parameter int unsigned OFF_US   = 125_000,
    parameter int unsigned REL_US   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_rx,
    input  logic [1:0] tmo_sel,
    output logic       tx_enable,
    output logic       tmo_flag
);

    localparam int unsigned SHORT_CYC = CLK_MHZ * SHORT_US;
    localparam int unsigned LONG_CYC  = CLK_MHZ * LONG_US;
    localparam int unsigned OFF_CYC   = CLK_MHZ * OFF_US;
    localparam int unsigned REL_CYC   = CLK_MHZ * REL_US;
    localparam int unsigned MAX_A     = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int unsigned MAX_B     = (OFF_CYC > REL_CYC) ? OFF_CYC : REL_CYC;
    localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW        = $clog2(MAX_CYC + 1);

    guard_state_e  state;
    logic          capture;
    logic [CW-1:0] sess_span;
    logic          armed;
    logic          sess_done;
    logic          off_done;
    logic          rel_done;
    logic          sess_run;
    logic          off_run;
    logic          rel_run;

    // A session opens on the edge where the idle state sees mode_rx low.
    assign capture  = (state == ST_RECV) && !mode_rx;
    assign sess_run = (state == ST_SEND);
    assign off_run  = (state == ST_HOLD);
    assign rel_run  = (state == ST_HOLD) && mode_rx;

    txg_limit_latch #(
        .CW       (CW),
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_limit (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .sel    (tmo_sel),
        .span   (sess_span),
        .armed  (armed)
    );

    txg_span_timer #(.CW(CW)) u_sess_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sess_run),
        .span (sess_span),
        .done (sess_done)
    );

    txg_span_timer #(.CW(CW)) u_off_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (off_run),
        .span (CW'(OFF_CYC)),
        .done (off_done)
    );

    txg_span_timer #(.CW(CW)) u_rel_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (rel_run),
        .span (CW'(REL_CYC)),
        .done (rel_done)
    );

    txg_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_rx  (mode_rx),
        .sess_done(sess_done),
        .armed    (armed),
        .off_done (off_done),
        .rel_done (rel_done),
        .state    (state),
        .tx_enable(tx_enable),
        .tmo_flag (tmo_flag)
    );

endmodule

// File: rtl/tx_session_guard_chk.sv
// Port-level protocol checker for tx_session_guard, attached by bind.
// The durations are tracked with counters, so no deep $past is needed.
module tx_session_guard_chk #(
    parameter int unsigned SHORT_CYC = 10,
    parameter int unsigned LONG_CYC  = 30,
    parameter int unsigned OFF_CYC   = 5,
    parameter int unsigned REL_CYC   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic mode_rx,
    input logic tx_enable,
    input logic tmo_flag
);

    logic [31:0] tx_cnt;
    logic [31:0] hold_cnt;
    logic [31:0] hi_cnt;

    // Count the consecutive sampled cycles of tx_enable, tmo_flag and mode_rx high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt   <= '0;
            hold_cnt <= '0;
            hi_cnt   <= '0;
        end else begin
            tx_cnt   <= tx_enable ? ((tx_cnt   != '1) ? tx_cnt   + 1 : tx_cnt)   : '0;
            hold_cnt <= tmo_flag  ? ((hold_cnt != '1) ? hold_cnt + 1 : hold_cnt) : '0;
            hi_cnt   <= mode_rx   ? ((hi_cnt   != '1) ? hi_cnt   + 1 : hi_cnt)   : '0;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_enable && !tmo_flag));

    assert_rxstop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rx |=> !tx_enable);

    assert_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> ($past(tx_enable) && !$past(mode_rx)));

    assert_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (tx_cnt == SHORT_CYC || tx_cnt == LONG_CYC));

    assert_offmin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_flag) |-> (hold_cnt >= OFF_CYC));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_flag) |-> ($past(mode_rx) && hi_cnt >= REL_CYC));

    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> (!$past(mode_rx) && !$past(tmo_flag)));

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_enable && tmo_flag));

endmodule

bind tx_session_guard tx_session_guard_chk #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC),
    .OFF_CYC  (OFF_CYC),
    .REL_CYC  (REL_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_rx  (mode_rx),
    .tx_enable(tx_enable),
    .tmo_flag (tmo_flag)
);

// File: tb/tx_session_guard_tb.sv
// Directed bench for tx_session_guard, with scaled-down durations.
// Inputs change on falling edges and outputs are sampled on falling edges.
module tx_session_guard_tb;

    localparam int SH  = 200;   // short limit in cycles (CLK_MHZ = 1)
    localparam int LG  = 500;
    localparam int OFF = 120;
    localparam int REL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rx = 1'b1;
    logic [1:0] tmo_sel = 2'b00;
    logic       tx_enable;
    logic       tmo_flag;
    int         n_run = 0;
    int         n_fail = 0;
    int         both_hi = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    tx_session_guard #(
        .CLK_MHZ (1),
        .SHORT_US(SH),
        .LONG_US (LG),
        .OFF_US  (OFF),
        .REL_US  (REL)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_rx  (mode_rx),
        .tmo_sel  (tmo_sel),
        .tx_enable(tx_enable),
        .tmo_flag (tmo_flag)
    );

    // R11 monitor: both outputs must never be high together.
    always @(negedge clk) begin
        cyc++;
        if (tx_enable && tmo_flag) both_hi++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic recover();
        mode_rx = 1'b1;
        for (int i = 0; i < OFF + REL + 10 && tmo_flag; i++) @(negedge clk);
        @(negedge clk);
        chk("R8 recovery clears flag", tmo_flag, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 tx_enable in reset", tx_enable, 0);
        chk("R1 flag in reset", tmo_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_enable after reset", tx_enable, 0);
        chk("R1 flag after reset", tmo_flag, 0);
    endtask

    task automatic t_basic();
        tmo_sel = 2'b01;
        mode_rx = 1'b0;
        @(negedge clk);
        chk("R2 tx opens", tx_enable, 1);
        repeat (3) @(negedge clk);
        mode_rx = 1'b1;
        @(negedge clk);
        chk("R2 tx closes", tx_enable, 0);
        chk("R2 no flag", tmo_flag, 0);
    endtask

    task automatic t_limit(input logic [1:0] sel, input int lim, input string tag);
        tmo_sel = sel;
        mode_rx = 1'b0;
        repeat (lim) @(negedge clk);
        chk({tag, " tx on last allowed cycle"}, tx_enable, 1);
        @(negedge clk);
        chk({tag, " tx off at limit"}, tx_enable, 0);
        chk({tag, " flag at limit"}, tmo_flag, 1);
    endtask

    task automatic t_short_off();
        t_limit(2'b01, SH, "R3");
        mode_rx = 1'b1;
        repeat (OFF - 1) @(negedge clk);
        chk("R7 flag held through off time", tmo_flag, 1);
        chk("R9 no tx during hold", tx_enable, 0);
        @(negedge clk);
        chk("R7 flag clears after off time", tmo_flag, 0);
    endtask

    task automatic t_long();
        t_limit(2'b10, LG, "R4 sel10");
        recover();
        t_limit(2'b11, LG, "R4 sel11");
        recover();
    endtask

    task automatic t_unlimited();
        tmo_sel = 2'b00;
        mode_rx = 1'b0;
        repeat (LG + 20) @(negedge clk);
        chk("R5 tx still on", tx_enable, 1);
        chk("R5 no flag", tmo_flag, 0);
        mode_rx = 1'b1;
        @(negedge clk);
        chk("R5 tx closes on mode", tx_enable, 0);
    endtask

    task automatic t_latch();
        tmo_sel = 2'b01;
        mode_rx = 1'b0;
        repeat (5) @(negedge clk);
        tmo_sel = 2'b00;
        repeat (SH - 5) @(negedge clk);
        chk("R6 tx on before captured limit", tx_enable, 1);
        @(negedge clk);
        chk("R6 captured limit trips", tmo_flag, 1);
        recover();
        tmo_sel = 2'b00;
        mode_rx = 1'b0;
        repeat (5) @(negedge clk);
        tmo_sel = 2'b01;
        repeat (SH + 20) @(negedge clk);
        chk("R6 late select ignored tx", tx_enable, 1);
        chk("R6 late select ignored flag", tmo_flag, 0);
        mode_rx = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_release();
        tmo_sel = 2'b01;
        mode_rx = 1'b0;
        repeat (SH + 1) @(negedge clk);
        chk("R3 trip before hold test", tmo_flag, 1);
        repeat (OFF + 5) @(negedge clk);
        chk("R8 flag held while mode low", tmo_flag, 1);
        chk("R9 tx blocked while mode low", tx_enable, 0);
        mode_rx = 1'b1;
        repeat (5) @(negedge clk);
        mode_rx = 1'b0;
        @(negedge clk);
        mode_rx = 1'b1;
        repeat (REL - 1) @(negedge clk);
        chk("R8 dip restarts release count", tmo_flag, 1);
        @(negedge clk);
        chk("R8 flag clears after release delay", tmo_flag, 0);
        chk("R9 tx stays off after release", tx_enable, 0);
        repeat (3) @(negedge clk);
        chk("R9 no session without mode low", tx_enable, 0);
        mode_rx = 1'b0;
        @(negedge clk);
        chk("R9 new session opens", tx_enable, 1);
        mode_rx = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_tie();
        tmo_sel = 2'b01;
        mode_rx = 1'b0;
        repeat (SH) @(negedge clk);
        mode_rx = 1'b1;
        @(negedge clk);
        chk("R10 tx closed at tie", tx_enable, 0);
        chk("R10 no flag at tie", tmo_flag, 0);
        repeat (3) @(negedge clk);
        chk("R10 flag stays clear", tmo_flag, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_short_off();
        t_long();
        t_unlimited();
        t_latch();
        t_release();
        t_tie();
        chk("R11 outputs never both high", both_hi, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule